// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sequences the two low-power modes of a small microcontroller core. The instruction decoder sends a one-cycle strobe when the core executes the wait instruction or the stop instruction. The sequencer then gates off the CPU clock. In stop mode it also turns the oscillator off. When a qualifying wakeup source appears, it brings the core back. Entering either mode clears the interrupt mask bit, so that interrupts can wake the core. A reset sets the mask bit again.

The two modes differ in what can wake them. Wait mode keeps the oscillator running, and any of the external interrupt, the internal interrupt or the break request ends it, with the CPU clock back on the next cycle. Stop mode listens only to the external interrupt and the break request. Its exit first re-enables the oscillator and then waits out a programmable stabilization count before the CPU clock is released. A stop exit caused by a break request sets a sticky break-wake flag. Software clears the flag by writing a zero.

A strobe that arrives while a source able to end the requested mode is already asserted still clears the mask, but the core stays running, so that the wakeup is not lost. The mode is visible on a two-bit code: 0 running, 1 wait, 2 stop, 3 stabilizing.

Top module: `pmode_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes to mode code 0 with `imask`=1, `brk_flag`=0, `cpu_clk_en`=1 and `osc_en`=1.
- R2: In mode 0, a `wait_stb` without `stop_stb` and with none of `ext_irq`, `int_irq`, `brk_req` high gives, from the next cycle, mode 1, `cpu_clk_en`=0, `osc_en`=1 and `imask`=0.
- R3: In mode 0, a `stop_stb` with neither `ext_irq` nor `brk_req` high gives, from the next cycle, mode 2, `cpu_clk_en`=0, `osc_en`=0 and `imask`=0. It takes priority when `wait_stb` is high in the same cycle.
- R4: In mode 1, any of `ext_irq`, `int_irq` or `brk_req` gives mode 0 with `cpu_clk_en`=1 on the next cycle, and `imask` stays 0.
- R5: In mode 2, `int_irq` has no effect. `ext_irq` or `brk_req` gives mode 3 on the next cycle, with `osc_en`=1 and `cpu_clk_en`=0.
- R6: Mode 3 lasts exactly `STAB_CYCLES` cycles and then becomes mode 0. Requests that arrive during mode 3 have no effect on it.
- R7: A strobe that arrives while a source able to end the requested mode is high leaves the block in mode 0, and `imask` still becomes 0.
- R8: `brk_flag` becomes 1 on the cycle after a `brk_req` ends mode 2. A break request that ends mode 1, or that is pending at a strobe, leaves the flag unchanged.
- R9: `flag_wr` with `flag_wr_val`=0 clears `brk_flag` on the next cycle, and `flag_wr_val`=1 has no effect. A break wake in the same cycle as a clearing write leaves the flag at 1.
- R10: `mask_wr` loads `mask_wr_val` into `imask` on the next cycle in mode 0 only. A mode-entry strobe in the same cycle wins, and `imask` becomes 0.
- R11: A reset in any mode, including mode 2 and mode 3, returns all outputs to the R1 values on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| wait_stb | input | 1 | One-cycle strobe from the decoder: wait instruction executed |
| stop_stb | input | 1 | One-cycle strobe from the decoder: stop instruction executed |
| ext_irq | input | 1 | External interrupt request |
| int_irq | input | 1 | Internal (peripheral) interrupt request |
| brk_req | input | 1 | Break interrupt request |
| mask_wr | input | 1 | Write strobe for the interrupt mask bit |
| mask_wr_val | input | 1 | Value for the interrupt mask write |
| flag_wr | input | 1 | Software write strobe for the break-wake flag |
| flag_wr_val | input | 1 | Value for the break-wake flag write (0 clears the flag) |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Oscillator enable |
| imask | output | 1 | Interrupt mask bit (1 = interrupts masked) |
| brk_flag | output | 1 | Sticky flag: the last stop exit was caused by a break request |
| mode | output | 2 | Mode code: 0 run, 1 wait, 2 stop, 3 stabilizing |

## Verification
Two pairs of functions can act in the same cycle. A mode-entry strobe can meet a pending wakeup source or a mask write. A break wake out of stop can meet a software write that clears the flag. The bench drives each pair on the same clock edge. For example, it raises `brk_req` together with a zero write to the flag while the block is in stop. It judges the result by the mode code, `imask` and `brk_flag` on the following cycle. A behavioural reference model, stepped every clock, also compares every output through a long random phase, where such collisions occur by chance.

// File: rtl/pmode_pkg.sv
package pmode_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_WAIT = 2'd1,
        PM_STOP = 2'd2,
        PM_STAB = 2'd3
    } pm_state_e;

    // Raw wakeup request lines.
    typedef struct packed {
        logic ext;
        logic intr;
        logic brk;
    } wake_src_t;

    // Wakeup requests qualified per low-power mode.
    typedef struct packed {
        logic any_wait;   // something that ends wait mode
        logic any_stop;   // something that ends stop mode
        logic brk_stop;   // the stop-ending source includes a break
    } wake_qual_t;

    // Events that the state machine hands to the timer and the status bits.
    typedef struct packed {
        logic lp_enter;   // a low-power instruction executed (mask clear)
        logic stab_load;  // stop exit begins: load the stabilization timer
        logic brk_wake;   // stop exit caused by a break
    } fsm_evt_t;

    function automatic logic ends_wait(input wake_src_t s);
        return s.ext | s.intr | s.brk;
    endfunction

    function automatic logic ends_stop(input wake_src_t s);
        return s.ext | s.brk;
    endfunction

endpackage

// File: rtl/pmode_wake_qual.sv
module pmode_wake_qual
    import pmode_pkg::*;
(
    input  wake_src_t  src,
    output wake_qual_t qual
);
    always_comb begin
        qual.any_wait = ends_wait(src);
        qual.any_stop = ends_stop(src);
        qual.brk_stop = src.brk;
    end

    // R5: the internal interrupt alone never qualifies for a stop exit
    always_comb begin
        assert_int_not_stop_R5: assert (!(src.intr && !src.ext && !src.brk) || !qual.any_stop);
    end
endmodule

// File: rtl/pmode_stab_timer.sv
module pmode_stab_timer #(
    parameter int unsigned STAB_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic done
);
    localparam int unsigned CW = $clog2(STAB_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(STAB_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= LOAD_VAL;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = run && (cnt == CW'(1));

    // R6: a load places the full count in the timer
    assert_load_full_R6: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == LOAD_VAL);
    // R6: the count never runs dry while stabilizing
    assert_live_count_R6: assert property (@(posedge clk) disable iff (rst)
        run |-> cnt != '0);
    // R6: every stabilizing cycle that does not finish moves the count down by one
    assert_step_down_R6: assert property (@(posedge clk) disable iff (rst)
        (run && !done && !load) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/pmode_fsm.sv
module pmode_fsm
    import pmode_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wait_stb,
    input  logic       stop_stb,
    input  wake_qual_t qual,
    input  logic       stab_done,
    output pm_state_e  state,
    output fsm_evt_t   evt
);
    pm_state_e nxt;

    always_comb begin
        nxt = state;
        evt = '0;
        unique case (state)
            PM_RUN: begin
                if (stop_stb) begin
                    evt.lp_enter = 1'b1;
                    if (!qual.any_stop) nxt = PM_STOP;
                end else if (wait_stb) begin
                    evt.lp_enter = 1'b1;
                    if (!qual.any_wait) nxt = PM_WAIT;
                end
            end
            PM_WAIT: begin
                if (qual.any_wait) nxt = PM_RUN;
            end
            PM_STOP: begin
                if (qual.any_stop) begin
                    nxt           = PM_STAB;
                    evt.stab_load = 1'b1;
                    evt.brk_wake  = qual.brk_stop;
                end
            end
            PM_STAB: begin
                if (stab_done) nxt = PM_RUN;
            end
            default: nxt = PM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PM_RUN;
        else     state <= nxt;
    end

    assert_wait_entry_R2: assert property (@(posedge clk) disable iff (rst)
        (state == PM_RUN && wait_stb && !stop_stb && !qual.any_wait) |=> state == PM_WAIT);
    assert_stop_entry_R3: assert property (@(posedge clk) disable iff (rst)
        (state == PM_RUN && stop_stb && !qual.any_stop) |=> state == PM_STOP);
    assert_wait_exit_R4: assert property (@(posedge clk) disable iff (rst)
        (state == PM_WAIT && qual.any_wait) |=> state == PM_RUN);
    assert_stop_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (state == PM_STOP && !qual.any_stop) |=> state == PM_STOP);
    assert_stab_from_stop_R6: assert property (@(posedge clk) disable iff (rst)
        (state == PM_STAB && $past(state) != PM_STAB) |-> $past(state) == PM_STOP);
    assert_pending_stays_R7: assert property (@(posedge clk) disable iff (rst)
        (state == PM_RUN && ((stop_stb && qual.any_stop) ||
                             (!stop_stb && wait_stb && qual.any_wait))) |=> state == PM_RUN);
endmodule

// File: rtl/pmode_status.sv
module pmode_status
    import pmode_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     in_run,
    input  fsm_evt_t evt,
    input  logic     mask_wr,
    input  logic     mask_wr_val,
    input  logic     flag_wr,
    input  logic     flag_wr_val,
    output logic     imask,
    output logic     brk_flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            imask <= 1'b1;
        end else if (evt.lp_enter) begin
            imask <= 1'b0;
        end else if (mask_wr && in_run) begin
            imask <= mask_wr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_flag <= 1'b0;
        end else if (evt.brk_wake) begin
            brk_flag <= 1'b1;
        end else if (flag_wr && !flag_wr_val) begin
            brk_flag <= 1'b0;
        end
    end

    assert_enter_unmasks_R2: assert property (@(posedge clk) disable iff (rst)
        evt.lp_enter |=> !imask);
    assert_mask_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (!in_run) |=> imask == $past(imask));
    assert_flag_set_R8: assert property (@(posedge clk) disable iff (rst)
        evt.brk_wake |=> brk_flag);
    assert_flag_rise_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(brk_flag) |-> $past(evt.brk_wake));
    assert_flag_one_write_R9: assert property (@(posedge clk) disable iff (rst)
        (flag_wr && flag_wr_val) |=> brk_flag == $past(brk_flag) || $past(evt.brk_wake));
endmodule

// File: rtl/pmode_ctrl.sv
module pmode_ctrl
    import pmode_pkg::*;
#(
    parameter int unsigned STAB_CYCLES = 4096
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wait_stb,
    input  logic       stop_stb,
    input  logic       ext_irq,
    input  logic       int_irq,
    input  logic       brk_req,
    input  logic       mask_wr,
    input  logic       mask_wr_val,
    input  logic       flag_wr,
    input  logic       flag_wr_val,
    output logic       cpu_clk_en,
    output logic       osc_en,
    output logic       imask,
    output logic       brk_flag,
    output logic [1:0] mode
);
    wake_src_t  src;
    wake_qual_t qual;
    pm_state_e  state;
    fsm_evt_t   evt;
    logic       stab_done;

    assign src = '{ext: ext_irq, intr: int_irq, brk: brk_req};

    pmode_wake_qual u_qual (
        .src  (src),
        .qual (qual)
    );

    pmode_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .wait_stb  (wait_stb),
        .stop_stb  (stop_stb),
        .qual      (qual),
        .stab_done (stab_done),
        .state     (state),
        .evt       (evt)
    );

    pmode_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (evt.stab_load),
        .run  (state == PM_STAB),
        .done (stab_done)
    );

    pmode_status u_status (
        .clk         (clk),
        .rst         (rst),
        .in_run      (state == PM_RUN),
        .evt         (evt),
        .mask_wr     (mask_wr),
        .mask_wr_val (mask_wr_val),
        .flag_wr     (flag_wr),
        .flag_wr_val (flag_wr_val),
        .imask       (imask),
        .brk_flag    (brk_flag)
    );

    assign cpu_clk_en = (state == PM_RUN);
    assign osc_en     = (state != PM_STOP);
    assign mode       = state;

    // R11: any reset brings the core back to running with the mask set
    assert_reset_exit_R11: assert property (@(posedge clk)
        rst |=> (mode == 2'd0 && imask && !brk_flag));
    // R3: the oscillator stays off for as long as stop mode lasts
    assert_stop_osc_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2 && !ext_irq && !brk_req) |=> !osc_en);
endmodule

// File: tb/pmode_ctrl_bench.sv
module pmode_ctrl_bench;
    localparam int STAB_N = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wait_stb = 0, stop_stb = 0, ext_irq = 0, int_irq = 0, brk_req = 0;
    logic mask_wr = 0, mask_wr_val = 0, flag_wr = 0, flag_wr_val = 0;
    logic cpu_clk_en, osc_en, imask, brk_flag;
    logic [1:0] mode;

    int errors = 0;
    int checks = 0;
    bit started = 0;
    bit finished = 0;

    // reference model state
    int m_mode = 0;
    bit m_imask = 1;
    bit m_flag = 0;
    int m_cnt = 0;

    always #5 clk = ~clk;

    pmode_ctrl #(.STAB_CYCLES(STAB_N)) u_pmode_ctrl (
        .clk(clk), .rst(rst), .wait_stb(wait_stb), .stop_stb(stop_stb),
        .ext_irq(ext_irq), .int_irq(int_irq), .brk_req(brk_req),
        .mask_wr(mask_wr), .mask_wr_val(mask_wr_val),
        .flag_wr(flag_wr), .flag_wr_val(flag_wr_val),
        .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .imask(imask),
        .brk_flag(brk_flag), .mode(mode)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model, one step per clock
    always @(posedge clk) begin
        bit set_now;
        started <= 1'b1;
        set_now = 0;
        if (rst) begin
            m_mode = 0; m_imask = 1; m_flag = 0; m_cnt = 0;
        end else begin
            case (m_mode)
                0: begin
                    if (stop_stb) begin
                        m_imask = 0;
                        if (!(ext_irq || brk_req)) m_mode = 2;
                    end else if (wait_stb) begin
                        m_imask = 0;
                        if (!(ext_irq || int_irq || brk_req)) m_mode = 1;
                    end else if (mask_wr) begin
                        m_imask = mask_wr_val;
                    end
                end
                1: if (ext_irq || int_irq || brk_req) m_mode = 0;
                2: if (ext_irq || brk_req) begin
                       m_mode = 3; m_cnt = STAB_N;
                       if (brk_req) begin m_flag = 1; set_now = 1; end
                   end
                default: begin
                    if (m_cnt == 1) m_mode = 0;
                    else m_cnt--;
                end
            endcase
            if (flag_wr && !flag_wr_val && !set_now) m_flag = 0;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !finished) begin
            check("mode R2/R3/R4/R5/R6/R7/R11", int'(mode), m_mode);
            check("imask R1/R2/R10", int'(imask), int'(m_imask));
            check("brk_flag R8/R9", int'(brk_flag), int'(m_flag));
            check("cpu_clk_en R4/R6", int'(cpu_clk_en), (m_mode == 0) ? 1 : 0);
            check("osc_en R3/R5", int'(osc_en), (m_mode != 2) ? 1 : 0);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_in();
        wait_stb = 0; stop_stb = 0; ext_irq = 0; int_irq = 0; brk_req = 0;
        mask_wr = 0; mask_wr_val = 0; flag_wr = 0; flag_wr_val = 0; rst = 0;
    endtask

    initial begin
        int stab_len;
        cyc(3);
        clear_in();
        cyc(1);
        // R1 reset state
        check("R1 mode", int'(mode), 0);
        check("R1 imask", int'(imask), 1);
        check("R1 brk_flag", int'(brk_flag), 0);
        check("R1 clocks", int'({cpu_clk_en, osc_en}), 3);

        // R2 wait entry, R4 wait exit by internal interrupt
        wait_stb = 1; cyc(1); clear_in(); cyc(1);
        check("R2 mode", int'(mode), 1);
        check("R2 imask", int'(imask), 0);
        check("R2 clocks", int'({cpu_clk_en, osc_en}), 1);
        cyc(3);
        int_irq = 1; cyc(1); clear_in(); cyc(1);
        check("R4 mode", int'(mode), 0);
        check("R4 cpu_clk_en", int'(cpu_clk_en), 1);
        check("R4 imask", int'(imask), 0);

        // R10 mask write, then R3 stop entry with a non-stop source present
        mask_wr = 1; mask_wr_val = 1; cyc(1); clear_in(); cyc(1);
        check("R10 mask write", int'(imask), 1);
        stop_stb = 1; int_irq = 1; cyc(1); clear_in(); cyc(1);
        check("R3 mode", int'(mode), 2);
        check("R3 clocks", int'({cpu_clk_en, osc_en}), 0);
        check("R3 imask", int'(imask), 0);
        // R10 mask write ignored outside run
        mask_wr = 1; mask_wr_val = 1; cyc(1); clear_in(); cyc(1);
        check("R10 ignored in stop", int'(imask), 0);
        // R5 internal interrupt ignored in stop
        int_irq = 1; cyc(2); clear_in(); cyc(1);
        check("R5 int ignored", int'(mode), 2);
        ext_irq = 1; cyc(1); clear_in();
        check("R5 stab mode", int'(mode), 3);
        check("R5 clocks", int'({cpu_clk_en, osc_en}), 1);
        // R6 stabilization length with requests during it
        stab_len = 0;
        while (mode == 2'd3 && stab_len < 100) begin
            stab_len++;
            brk_req = (stab_len == 2); ext_irq = (stab_len == 3);
            cyc(1);
        end
        clear_in();
        check("R6 stab length", stab_len, STAB_N);
        check("R6 back to run", int'(mode), 0);
        check("R8 no flag from stab break", int'(brk_flag), 0);

        // R3 priority, R8/R9 break wake with a same-cycle clearing write
        stop_stb = 1; wait_stb = 1; cyc(1); clear_in(); cyc(1);
        check("R3 stop priority", int'(mode), 2);
        brk_req = 1; flag_wr = 1; flag_wr_val = 0; cyc(1); clear_in(); cyc(1);
        check("R8 flag set", int'(brk_flag), 1);
        check("R9 set beats clear", int'(brk_flag), 1);
        cyc(STAB_N + 1);
        check("R6 run after break wake", int'(mode), 0);
        flag_wr = 1; flag_wr_val = 1; cyc(1); clear_in(); cyc(1);
        check("R9 one write no effect", int'(brk_flag), 1);
        flag_wr = 1; flag_wr_val = 0; cyc(1); clear_in(); cyc(1);
        check("R9 zero write clears", int'(brk_flag), 0);

        // R7 pending wakeup at the strobe
        mask_wr = 1; mask_wr_val = 1; cyc(1); clear_in();
        wait_stb = 1; int_irq = 1; cyc(1); clear_in(); cyc(1);
        check("R7 wait pending mode", int'(mode), 0);
        check("R7 wait pending imask", int'(imask), 0);
        stop_stb = 1; brk_req = 1; cyc(1); clear_in(); cyc(1);
        check("R7 stop pending mode", int'(mode), 0);
        check("R8 no flag from pending", int'(brk_flag), 0);
        // R10 strobe wins over a same-cycle mask write
        mask_wr = 1; mask_wr_val = 1; wait_stb = 1; cyc(1); clear_in(); cyc(1);
        check("R10 strobe wins", int'(imask), 0);
        check("R2 wait again", int'(mode), 1);
        brk_req = 1; cyc(1); clear_in(); cyc(1);
        check("R4 break ends wait", int'(mode), 0);
        check("R8 no flag from wait", int'(brk_flag), 0);

        // R11 reset out of stop and out of stabilization
        stop_stb = 1; cyc(1); clear_in(); cyc(2);
        rst = 1; cyc(1); clear_in();
        check("R11 reset from stop mode", int'(mode), 0);
        check("R11 reset imask", int'(imask), 1);
        stop_stb = 1; cyc(1); clear_in(); brk_req = 1; cyc(1); clear_in(); cyc(2);
        rst = 1; cyc(1); clear_in();
        check("R11 reset from stab", int'(mode), 0);
        check("R11 reset flag", int'(brk_flag), 0);

        // random phase compared cycle by cycle against the model
        for (int i = 0; i < 3000; i++) begin
            wait_stb    = ($urandom_range(0, 15) == 0);
            stop_stb    = ($urandom_range(0, 15) == 0);
            ext_irq     = ($urandom_range(0, 30) == 0);
            int_irq     = ($urandom_range(0, 10) == 0);
            brk_req     = ($urandom_range(0, 30) == 0);
            mask_wr     = ($urandom_range(0, 7) == 0);
            mask_wr_val = $urandom_range(0, 1);
            flag_wr     = ($urandom_range(0, 20) == 0);
            flag_wr_val = $urandom_range(0, 1);
            rst         = ($urandom_range(0, 400) == 0);
            cyc(1);
        end
        clear_in();
        cyc(2);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule